// File: doc/BRIEF.md
# Multi-Select SPI Master Sequencer

This block is an SPI master that runs one half-duplex transaction at a time. Each transaction is addressed to one of up to four peripherals, and each peripheral has its own active-low select line. A transaction starts when a descriptor is accepted. The descriptor names the target line, the number of bytes to send, whether a read phase follows and how many bytes it returns, and whether the clock stays silent during the closing guard period.

Outgoing bytes come in on a valid/ready stream and are shifted out most significant bit first. The clock idles low, and MOSI changes only while SCK is low. If the descriptor asks for a read, the block then clocks in the requested number of bytes from MISO, sampling on the rising edge, and hands each byte out on a second valid/ready stream. When either stream stalls, SCK holds low.

After the last byte, every select line is released. A guard period of eight SCK periods then follows before the block reports idle. In silent mode the SCK output enable is dropped for the whole guard period, so no clock edges reach the bus.

Top module: `spi_seq_master`

## Requirements
- R1: While a transaction is active, exactly one select line is low. That line is `cs_n_o[i]`, where `i` is the descriptor's `req_sel_i`. The line stays low from selection until release.
- R2: After reset and while idle, all `cs_n_o` lines are high, `sck_o` is low, `sck_oe_o` is high and `busy_o` is low.
- R3: When a descriptor is accepted, the selected line goes low in the cycle after the accepting edge. In that same update, `sck_o` and `mosi_o` are both low.
- R4: Write bytes leave MSB first. `mosi_o` changes only while `sck_o` is low, and each high phase of `sck_o` lasts exactly `HALF_DIV` clocks.
- R5: Read bytes are sampled from `miso_i` on the rising SCK edge, MSB first. They are delivered on `rd_valid_o`/`rd_data_o`. SCK stays low while a read byte is waiting or a write byte is missing.
- R6: `req_wlen_i` holds the write byte count minus one, in 16 bits. `req_rlen_i` holds the read byte count minus one, in 16 bits, and is used only when `req_rd_i` is 1. With `req_rd_i` at 0 there is no read phase, and the number of SCK rising edges while selected equals 8 × (`req_wlen_i`+1).
- R7: After the last byte, all select lines go high. While they are high, eight SCK periods (eight rising edges) pass before `busy_o` falls.
- R8: When `req_quiet_i` is 1, `sck_oe_o` is low and `sck_o` has no rising edge for the whole guard period. `sck_oe_o` is high again by the cycle `busy_o` falls, and it is never low outside a silent guard period.
- R9: A descriptor whose `req_sel_i` is at or above `NUM_SEL` produces a one-cycle `err_o` pulse in the cycle after acceptance. No select line moves and `busy_o` stays low.
- R10: `busy_o` is high from the cycle after a valid descriptor is accepted until the guard period ends. `req_ready_o` is high exactly when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Descriptor valid |
| req_ready_o | output | 1 | Descriptor accepted (idle) |
| req_sel_i | input | 2 | Target select line index |
| req_wlen_i | input | 16 | Write byte count minus one |
| req_rd_i | input | 1 | Read phase requested |
| req_rlen_i | input | 16 | Read byte count minus one |
| req_quiet_i | input | 1 | Silent clock during guard |
| wr_valid_i | input | 1 | Write byte valid |
| wr_ready_o | output | 1 | Write byte taken |
| wr_data_i | input | 8 | Write byte |
| rd_valid_o | output | 1 | Read byte valid |
| rd_ready_i | input | 1 | Read byte taken |
| rd_data_o | output | 8 | Read byte |
| sck_o | output | 1 | Serial clock |
| sck_oe_o | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | NUM_SEL | Active-low select lines |
| busy_o | output | 1 | Transaction in progress |
| err_o | output | 1 | Rejected descriptor pulse |

## Verification
Two events can fall in the same cycle, and both involve the bit engine's end of byte. The first is the final falling SCK edge of the last write byte, which coincides with the switch to the read phase and reloads the bit counter without a pause. The second is a write-stream handshake arriving on the very cycle the previous byte completes. The bench provokes both by holding the write stream continuously valid in some transactions and inserting random gaps and read back-pressure in others. It judges them with a bus-level slave model that counts rising SCK edges and rebuilds every byte from MOSI. Any lost, doubled or shifted bit at the boundary shows up as a wrong byte or a wrong edge count.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

   localparam int unsigned SEL_W  = 2;
   localparam int unsigned LEN_W  = 16;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WAIT_WR,
      S_SHIFT,
      S_PUSH_RD,
      S_RELEASE,
      S_GUARD,
      S_RESTORE
   } seq_state_e;

endpackage

// File: rtl/spi_seq_tick.sv
// Half-period strobe: one pulse every HALF_DIV clocks while run is high.
module spi_seq_tick #(
   parameter int unsigned HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (HALF_DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int unsigned CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (!run)         cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                   cnt_q <= cnt_q + CW'(1);
         end
         assign tick = run && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/spi_seq_lencnt.sv
// Remaining-byte counter holding count minus one.
module spi_seq_lencnt #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         last
);
   logic [W-1:0] cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (dec)  cnt_q <= cnt_q - W'(1);
   end
   assign last = (cnt_q == '0);
endmodule

// File: rtl/spi_seq_csdrv.sv
// One registered active-low line per peripheral.
module spi_seq_csdrv #(
   parameter int unsigned NUM_SEL = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               select_en,
   input  logic               release_en,
   input  logic [1:0]         sel,
   output logic [NUM_SEL-1:0] cs_n
);
   generate
      for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cs_n[i] <= 1'b1;
            else if (release_en)                 cs_n[i] <= 1'b1;
            else if (select_en && sel == 2'(i))  cs_n[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master #(
   parameter int unsigned NUM_SEL       = 4,
   parameter int unsigned HALF_DIV      = 2,
   parameter int unsigned GUARD_PERIODS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   output logic               req_ready_o,
   input  logic [1:0]         req_sel_i,
   input  logic [15:0]        req_wlen_i,
   input  logic               req_rd_i,
   input  logic [15:0]        req_rlen_i,
   input  logic               req_quiet_i,
   input  logic               wr_valid_i,
   output logic               wr_ready_o,
   input  logic [7:0]         wr_data_i,
   output logic               rd_valid_o,
   input  logic               rd_ready_i,
   output logic [7:0]         rd_data_o,
   output logic               sck_o,
   output logic               sck_oe_o,
   output logic               mosi_o,
   input  logic               miso_i,
   output logic [NUM_SEL-1:0] cs_n_o,
   output logic               busy_o,
   output logic               err_o
);
   import spi_seq_pkg::*;

   localparam int unsigned GMAX = (GUARD_PERIODS > BYTE_W) ? GUARD_PERIODS : BYTE_W;
   localparam int unsigned BCW  = $clog2(GMAX);
   localparam logic [BCW-1:0] BIT_TOP   = BCW'(BYTE_W - 1);
   localparam logic [BCW-1:0] GUARD_TOP = BCW'(GUARD_PERIODS - 1);
   localparam logic [SEL_W:0] SEL_LIM   = (SEL_W+1)'(NUM_SEL);

   generate
      if (NUM_SEL < 1 || NUM_SEL > 4) begin : g_bad_nsel
         initial $fatal(1, "NUM_SEL must be 1..4");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         initial $fatal(1, "HALF_DIV must be at least 1");
      end
      if (GUARD_PERIODS < 1) begin : g_bad_guard
         initial $fatal(1, "GUARD_PERIODS must be at least 1");
      end
   endgenerate

   seq_state_e        state_q;
   logic              rd_en_q, quiet_q, rd_phase_q;
   logic [BYTE_W-1:0] sh_q;
   logic [BCW-1:0]    bit_q;
   logic              hi_q, sck_q, oe_q, mosi_q, err_q;

   logic tick, accept, accept_ok, fall_end, byte_done;
   logic w_last, r_last, w_dec, r_dec;

   assign accept    = (state_q == S_IDLE) && req_valid_i;
   assign accept_ok = accept && ({1'b0, req_sel_i} < SEL_LIM);
   assign fall_end  = (state_q == S_SHIFT) && tick && hi_q;
   assign byte_done = fall_end && (bit_q == '0);
   assign w_dec     = byte_done && !rd_phase_q && !w_last;
   assign r_dec     = (state_q == S_PUSH_RD) && rd_ready_i && !r_last;

   spi_seq_tick #(.HALF_DIV(HALF_DIV)) i_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  ((state_q == S_SHIFT) || (state_q == S_GUARD)),
      .tick (tick)
   );

   spi_seq_lencnt #(.W(LEN_W)) i_wcnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept_ok),
      .load_val(req_wlen_i),
      .dec     (w_dec),
      .last    (w_last)
   );

   spi_seq_lencnt #(.W(LEN_W)) i_rcnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept_ok),
      .load_val(req_rlen_i),
      .dec     (r_dec),
      .last    (r_last)
   );

   spi_seq_csdrv #(.NUM_SEL(NUM_SEL)) i_cs (
      .clk       (clk),
      .rst_n     (rst_n),
      .select_en (accept_ok),
      .release_en(state_q == S_RELEASE),
      .sel       (req_sel_i),
      .cs_n      (cs_n_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         rd_en_q    <= 1'b0;
         quiet_q    <= 1'b0;
         rd_phase_q <= 1'b0;
         sh_q       <= '0;
         bit_q      <= '0;
         hi_q       <= 1'b0;
         sck_q      <= 1'b0;
         oe_q       <= 1'b1;
         mosi_q     <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (accept) begin
                  if (accept_ok) begin
                     rd_en_q    <= req_rd_i;
                     quiet_q    <= req_quiet_i;
                     rd_phase_q <= 1'b0;
                     sck_q      <= 1'b0;
                     hi_q       <= 1'b0;
                     mosi_q     <= 1'b0;
                     oe_q       <= 1'b1;
                     state_q    <= S_WAIT_WR;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            S_WAIT_WR: begin
               if (wr_valid_i) begin
                  sh_q    <= wr_data_i;
                  mosi_q  <= wr_data_i[BYTE_W-1];
                  bit_q   <= BIT_TOP;
                  hi_q    <= 1'b0;
                  state_q <= S_SHIFT;
               end
            end
            S_SHIFT: begin
               if (tick) begin
                  if (!hi_q) begin
                     hi_q  <= 1'b1;
                     sck_q <= 1'b1;
                     if (rd_phase_q) sh_q <= {sh_q[BYTE_W-2:0], miso_i};
                  end else begin
                     hi_q  <= 1'b0;
                     sck_q <= 1'b0;
                     if (bit_q != '0) begin
                        bit_q <= bit_q - BCW'(1);
                        if (!rd_phase_q) begin
                           sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
                           mosi_q <= sh_q[BYTE_W-2];
                        end
                     end else if (rd_phase_q) begin
                        state_q <= S_PUSH_RD;
                     end else if (!w_last) begin
                        state_q <= S_WAIT_WR;
                     end else if (rd_en_q) begin
                        rd_phase_q <= 1'b1;
                        bit_q      <= BIT_TOP;
                        mosi_q     <= 1'b0;
                     end else begin
                        mosi_q  <= 1'b0;
                        state_q <= S_RELEASE;
                     end
                  end
               end
            end
            S_PUSH_RD: begin
               if (rd_ready_i) begin
                  if (r_last) begin
                     state_q <= S_RELEASE;
                  end else begin
                     bit_q   <= BIT_TOP;
                     hi_q    <= 1'b0;
                     state_q <= S_SHIFT;
                  end
               end
            end
            S_RELEASE: begin
               mosi_q  <= 1'b0;
               oe_q    <= !quiet_q;
               bit_q   <= GUARD_TOP;
               hi_q    <= 1'b0;
               state_q <= S_GUARD;
            end
            S_GUARD: begin
               if (tick) begin
                  if (!hi_q) begin
                     hi_q  <= 1'b1;
                     sck_q <= !quiet_q;
                  end else begin
                     hi_q  <= 1'b0;
                     sck_q <= 1'b0;
                     if (bit_q == '0) state_q <= S_RESTORE;
                     else             bit_q   <= bit_q - BCW'(1);
                  end
               end
            end
            S_RESTORE: begin
               oe_q    <= 1'b1;
               sck_q   <= 1'b0;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready_o = (state_q == S_IDLE);
   assign wr_ready_o  = (state_q == S_WAIT_WR);
   assign rd_valid_o  = (state_q == S_PUSH_RD);
   assign rd_data_o   = sh_q;
   assign sck_o       = sck_q;
   assign sck_oe_o    = oe_q;
   assign mosi_o      = mosi_q;
   assign busy_o      = (state_q != S_IDLE);
   assign err_o       = err_q;

endmodule

// File: rtl/spi_seq_master_chk.sv
module spi_seq_master_chk #(
   parameter int unsigned NUM_SEL = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid_i,
   input logic               req_ready_o,
   input logic [1:0]         req_sel_i,
   input logic               sck_o,
   input logic               sck_oe_o,
   input logic               mosi_o,
   input logic [NUM_SEL-1:0] cs_n_o,
   input logic               busy_o,
   input logic               err_o
);
   localparam logic [2:0] LIM = 3'(NUM_SEL);

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n_o)); // R1

   AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (&cs_n_o) && sck_oe_o && !sck_o); // R2

   AST_SELECT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_ready_o && ({1'b0, req_sel_i} < LIM))
      |=> !(&cs_n_o) && !sck_o && !mosi_o); // R3

   AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_o && $past(sck_o)) |-> $stable(mosi_o)); // R4

   AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_oe_o |-> (&cs_n_o) && !sck_o && busy_o); // R8

   AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_ready_o && ({1'b0, req_sel_i} >= LIM))
      |=> err_o && !busy_o && (&cs_n_o)); // R9

   AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !busy_o && (&cs_n_o)); // R9

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_ready_o && ({1'b0, req_sel_i} < LIM)) |=> busy_o); // R10

   AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready_o |-> !busy_o); // R10

endmodule

bind spi_seq_master spi_seq_master_chk #(.NUM_SEL(NUM_SEL)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid_i(req_valid_i),
   .req_ready_o(req_ready_o),
   .req_sel_i  (req_sel_i),
   .sck_o      (sck_o),
   .sck_oe_o   (sck_oe_o),
   .mosi_o     (mosi_o),
   .cs_n_o     (cs_n_o),
   .busy_o     (busy_o),
   .err_o      (err_o)
);

// File: tb/test_spi_seq_master.sv
`timescale 1ns/1ps
module test_spi_seq_master;
   localparam int NSEL  = 3;
   localparam int HALF  = 2;
   localparam int GUARD = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_rd = 0, req_quiet = 0;
   logic [1:0] req_sel = '0;
   logic [15:0] req_wlen = '0, req_rlen = '0;
   logic wr_valid = 0, rd_ready = 0, miso = 0;
   logic [7:0] wr_data = '0;
   logic req_ready, wr_ready, rd_valid, sck, sck_oe, mosi, busy, err;
   logic [7:0] rd_data;
   logic [NSEL-1:0] cs_n;

   always #2 clk = ~clk;

   spi_seq_master #(.NUM_SEL(NSEL), .HALF_DIV(HALF), .GUARD_PERIODS(GUARD)) i_spi_seq_master (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_sel_i(req_sel),
      .req_wlen_i(req_wlen), .req_rd_i(req_rd), .req_rlen_i(req_rlen), .req_quiet_i(req_quiet),
      .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
      .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
      .sck_o(sck), .sck_oe_o(sck_oe), .mosi_o(mosi), .miso_i(miso),
      .cs_n_o(cs_n), .busy_o(busy), .err_o(err)
   );

   int errors = 0, checks = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // bus-level slave model
   logic [7:0] wbuf [0:15];
   logic [7:0] rbuf [0:15];
   logic [7:0] got_w [0:15];
   logic [7:0] got_r [0:15];
   int cur_nw = 0, cur_nr = 0;
   bit cur_quiet = 0;
   logic [NSEL-1:0] exp_cs = '1;
   int k = 0, guard_edges = 0, cs_bad = 0, quiet_seen = 0, oe_bad = 0;
   int hi_run = 0, hi_bad = 0, busy_bad = 0;

   function automatic logic miso_bit(input int kk);
      int idx;
      if (kk < 8*cur_nw || kk >= 8*(cur_nw+cur_nr)) return 1'b0;
      idx = kk - 8*cur_nw;
      return rbuf[idx/8][7-(idx%8)];
   endfunction

   always @(posedge sck) begin
      if (cs_n != '1) begin
         if (cs_n != exp_cs) cs_bad++;
         if (k < 8*cur_nw) got_w[k/8][7-(k%8)] = mosi;
         k++;
         miso = miso_bit(k);
      end else if (busy) begin
         guard_edges++;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy && (&cs_n) && cur_quiet && !sck_oe) quiet_seen++;
         if (!sck_oe && !(busy && cur_quiet)) oe_bad++;
         if (sck) hi_run++;
         else begin
            if (hi_run != 0 && hi_run != HALF) hi_bad++;
            hi_run = 0;
         end
         if ((cs_n != '1) && !busy) busy_bad++;
         if (busy && req_ready) busy_bad++;
      end
   end

   task automatic run_txn(input int sel, input int nw, input int nr, input bit quiet,
                          input bit wgap, input bit rgap);
      int wb_err = 0, rb_err = 0;
      for (int i = 0; i < nw; i++) wbuf[i] = 8'($urandom);
      for (int i = 0; i < nr; i++) rbuf[i] = 8'($urandom);
      cur_nw = nw; cur_nr = nr; cur_quiet = quiet;
      exp_cs = ~(NSEL'(1) << sel);
      k = 0; guard_edges = 0; quiet_seen = 0; cs_bad = 0;
      miso = miso_bit(0);
      @(negedge clk);
      req_valid = 1; req_sel = 2'(sel); req_wlen = 16'(nw-1);
      req_rd = (nr != 0); req_rlen = (nr != 0) ? 16'(nr-1) : 16'(0); req_quiet = quiet;
      @(negedge clk);
      req_valid = 0;
      chk(cs_n == exp_cs && !sck && !mosi && busy, "R3 select entry", int'(cs_n), int'(exp_cs));
      fork
         begin : feeder
            int i = 0;
            bit fl = 0;
            while (i < nw) begin
               @(negedge clk);
               if (fl) begin i++; wr_valid = 0; end
               fl = 0;
               if (i < nw) begin
                  if (wgap && ($urandom % 3 == 0)) wr_valid = 0;
                  else begin wr_valid = 1; wr_data = wbuf[i]; end
                  fl = wr_valid && wr_ready;
               end
            end
            wr_valid = 0;
         end
         begin : reader
            int j = 0;
            bit fl = 0;
            logic [7:0] saved = '0;
            while (j < nr) begin
               @(negedge clk);
               if (fl) begin got_r[j] = saved; j++; end
               fl = 0;
               if (j < nr) begin
                  rd_ready = rgap ? 1'($urandom % 2) : 1'b1;
                  fl = rd_ready && rd_valid;
                  saved = rd_data;
               end
            end
            rd_ready = 0;
         end
      join
      while (busy) @(negedge clk);
      for (int i = 0; i < nw; i++) if (got_w[i] !== wbuf[i]) wb_err++;
      for (int i = 0; i < nr; i++) if (got_r[i] !== rbuf[i]) rb_err++;
      chk(wb_err == 0, "R4 write bytes MSB first", wb_err, 0);
      if (nr != 0) chk(rb_err == 0, "R5 read bytes MSB first", rb_err, 0);
      chk(k == 8*(nw+nr), "R6 edges while selected", k, 8*(nw+nr));
      chk(cs_bad == 0, "R1 single selected line", cs_bad, 0);
      if (quiet) begin
         chk(guard_edges == 0, "R8 silent guard edges", guard_edges, 0);
         chk(quiet_seen >= 2*HALF*GUARD, "R8 silent guard oe low", quiet_seen, 2*HALF*GUARD);
      end else begin
         chk(guard_edges == GUARD, "R7 guard periods", guard_edges, GUARD);
      end
      chk(sck_oe && (&cs_n) && !sck && req_ready, "R2 idle restored", int'(sck_oe), 1);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(cs_n == '1 && !sck && sck_oe && !busy && !err && req_ready, "R2 reset state", int'(cs_n), (1<<NSEL)-1);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // directed: single byte, no read, continuous valid
      run_txn(0, 1, 0, 0, 0, 0);
      // directed: write then read, silent guard, back-pressure
      run_txn(2, 2, 3, 1, 1, 1);
      // directed: back-to-back bytes into read phase with no stalls
      run_txn(1, 4, 2, 0, 0, 0);

      // rejected index
      @(negedge clk);
      req_valid = 1; req_sel = 2'd3; req_wlen = 16'd0; req_rd = 0; req_quiet = 0;
      @(negedge clk);
      req_valid = 0;
      chk(err && (&cs_n) && !busy, "R9 reject pulse", int'(err), 1);
      @(negedge clk);
      chk(!err && (&cs_n) && !busy && req_ready, "R9 pulse one cycle", int'(err), 0);

      for (int t = 0; t < 12; t++) begin
         run_txn(int'($urandom % NSEL), 1 + int'($urandom % 5), int'($urandom % 5),
                 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
      end

      chk(hi_bad == 0, "R4 high phase width", hi_bad, 0);
      chk(oe_bad == 0, "R8 oe low only in silent guard", oe_bad, 0);
      chk(busy_bad == 0, "R10 busy covers selection", busy_bad, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule